// File: doc/BRIEF.md
# Parallel-Prefix Binary Adder (Brent-Kung Carry Tree)

This block adds two unsigned binary operands and a carry-in, and gives back the sum word and the carry-out. It uses no clock and holds no state. The carries do not ripple from bit to bit. Each bit position first forms a generate/propagate pair. A tree of associative carry operators then builds the prefix pairs. The tree is recursive:

- One row merges neighbouring pairs.
- A network of half the width runs on the merged pairs.
- A final row fills in the even positions that the half-width network left open.

An XOR row forms the sum bits from the carries.

The carry-in enters the tree as the generate of an imaginary position below bit 0. The adder folds it into the bit-0 generate term before the tree, so the tree itself always spans exactly `WIDTH` positions. The carry into position i is the prefix generate over positions 0 through i-1. The carry-out is the carry into position `WIDTH`.

`WIDTH` must be a power of two of at least 2, and its default is 8. The logic depth grows with the base-2 logarithm of the width.

The house stream handshake does not apply here, because no data is held or transferred. The block is a plain function of its three inputs. A surrounding pipeline registers its result wherever the timing budget allows.

Top module: `bk_adder`

## Requirements
- R1: `sum_o` equals the low `WIDTH` bits of `a_i + b_i + carry_in`, read as unsigned numbers.
- R2: `carry_out` equals bit `WIDTH` of the full-width result `a_i + b_i + carry_in`, for example 0x80 + 0x80 with a carry-in of 0, which gives a sum of 0x00 and a carry-out of 1.
- R3: When every bit position propagates (`b_i` is the bitwise complement of `a_i`), the carry-in passes straight through to `carry_out`, and `sum_o` is all ones when the carry-in is 0 or all zeros when it is 1.
- R4: An all-ones operand plus 1, given either as the other operand or as the carry-in, gives a sum of zero and a carry-out of 1.
- R5: The prefix generate at each position i ≥ 1 out of the carry tree equals the bit generate at i OR'd with (the bit propagate at i AND'd with the prefix generate at i-1), which is the ripple recurrence.
- R6: The prefix propagate at each position out of the carry tree equals the AND of all bit propagates from position 0 up to that position.
- R7: The carry-in acts as a generate below bit 0: with both operands zero, `sum_o` equals the carry-in in bit 0 with zeros elsewhere, and `carry_out` is 0.
- R8: The outputs are a combinational function of the current inputs only. Any earlier input sequence has no effect on them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The immediate assertions check four things whenever any input changes:

- the whole result against a behavioural sum;
- the carry passing through on an all-propagate pattern;
- the carry-in acting as a bit-0 generate;
- inside every level of the recursive tree, the ripple recurrence on the prefix generates and the running AND on the prefix propagates.

Some behaviours cannot be seen as a single-instant property, and only the bench's scenarios show them. One is that the outputs do not depend on the order in which operands were applied earlier. The bench shows this by revisiting earlier operand pairs after unrelated traffic. Another is that the corner patterns produce their exact expected words. The bench also sweeps every operand pair and carry-in at the default width.

// File: rtl/bk_pkg.sv
package bk_pkg;

  // Associative carry operator: merge a more significant group (hi) with the
  // adjacent less significant group (lo). Result packed as {g, p}.
  function automatic logic [1:0] bk_merge(input logic hi_g, input logic hi_p,
                                          input logic lo_g, input logic lo_p);
    logic [1:0] r;
    r[1] = hi_g | (hi_p & lo_g);
    r[0] = hi_p & lo_p;
    return r;
  endfunction

endpackage

// File: rtl/bk_gp_gen.sv
module bk_gp_gen #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  output logic [WIDTH-1:0] gen_o,
  output logic [WIDTH-1:0] prop_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign gen_o[i]  = x_i[i] & y_i[i];
    assign prop_o[i] = x_i[i] ^ y_i[i];
  end
endmodule

// File: rtl/bk_prefix.sv
module bk_prefix #(
  parameter int W = 8
) (
  input  logic [W-1:0] g_i,
  input  logic [W-1:0] p_i,
  output logic [W-1:0] g_o,
  output logic [W-1:0] p_o
);
  import bk_pkg::*;

  if (W == 1) begin : g_leaf
    assign g_o = g_i;
    assign p_o = p_i;
  end else begin : g_node
    localparam int H = W / 2;
    logic [H-1:0] pair_g, pair_p;
    logic [H-1:0] sub_g, sub_p;

    // Upper row: merge each odd position with the even position below it.
    for (genvar j = 0; j < H; j++) begin : g_upper
      logic [1:0] m;
      assign m = bk_merge(g_i[2*j+1], p_i[2*j+1], g_i[2*j], p_i[2*j]);
      assign pair_g[j] = m[1];
      assign pair_p[j] = m[0];
    end

    // Half-width network on the pair results.
    bk_prefix #(.W(H)) i_half (
      .g_i(pair_g),
      .p_i(pair_p),
      .g_o(sub_g),
      .p_o(sub_p)
    );

    assign g_o[0] = g_i[0];
    assign p_o[0] = p_i[0];

    // Odd positions come straight from the half network.
    for (genvar j = 0; j < H; j++) begin : g_odd
      assign g_o[2*j+1] = sub_g[j];
      assign p_o[2*j+1] = sub_p[j];
    end

    // Lower row: even positions above 0 take one more merge.
    for (genvar j = 1; j < H; j++) begin : g_even
      logic [1:0] m;
      assign m = bk_merge(g_i[2*j], p_i[2*j], sub_g[j-1], sub_p[j-1]);
      assign g_o[2*j] = m[1];
      assign p_o[2*j] = m[0];
    end

    always_comb begin
      for (int i = 1; i < W; i++) begin
        p_ripple_gen_r5: assert (g_o[i] == (g_i[i] | (p_i[i] & g_o[i-1])))
          else $error("R5 prefix generate breaks recurrence at %0d", i);
        p_group_prop_r6: assert (p_o[i] == (p_i[i] & p_o[i-1]))
          else $error("R6 prefix propagate is not a running AND at %0d", i);
      end
      p_base_r6: assert (p_o[0] == p_i[0] && g_o[0] == g_i[0])
        else $error("R6 position 0 not passed through");
    end
  end
endmodule

// File: rtl/bk_sum.sv
module bk_sum #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] prop_i,
  input  logic [WIDTH-1:0] carry_i,
  output logic [WIDTH-1:0] sum_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_xor
    assign sum_o[i] = prop_i[i] ^ carry_i[i];
  end
endmodule

// File: rtl/bk_adder.sv
module bk_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_out
);
  localparam int LOG_W = $clog2(WIDTH);

  if (WIDTH < 2 || (1 << LOG_W) != WIDTH) begin : g_bad_width
    $error("bk_adder: WIDTH must be a power of two of at least 2");
  end

  logic [WIDTH-1:0] bit_g, bit_p;
  logic [WIDTH-1:0] tree_g_in;
  logic [WIDTH-1:0] pre_g, pre_p;
  logic [WIDTH:0]   carry;

  bk_gp_gen #(.WIDTH(WIDTH)) i_gp (
    .x_i   (a_i),
    .y_i   (b_i),
    .gen_o (bit_g),
    .prop_o(bit_p)
  );

  // Carry-in is the generate of position -1; merge it into bit 0.
  if (WIDTH > 1) begin : g_fold
    assign tree_g_in = {bit_g[WIDTH-1:1], bit_g[0] | (bit_p[0] & carry_in)};
  end else begin : g_fold1
    assign tree_g_in = bit_g[0] | (bit_p[0] & carry_in);
  end

  bk_prefix #(.W(WIDTH)) i_tree (
    .g_i(tree_g_in),
    .p_i(bit_p),
    .g_o(pre_g),
    .p_o(pre_p)
  );

  assign carry = {pre_g, carry_in};

  bk_sum #(.WIDTH(WIDTH)) i_sum (
    .prop_i (bit_p),
    .carry_i(carry[WIDTH-1:0]),
    .sum_o  (sum_o)
  );

  assign carry_out = carry[WIDTH];

  always_comb begin
    p_total_r1: assert ({carry_out, sum_o} ==
                        ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_in}))
      else $error("R1/R2 result mismatch");
    if (&pre_p) begin
      p_pass_through_r3: assert (carry_out == carry_in && sum_o == {WIDTH{~carry_in}})
        else $error("R3 all-propagate pattern did not pass carry");
    end
    if (a_i == '0 && b_i == '0) begin
      p_cin_gen_r7: assert (carry_out == 1'b0 && sum_o == {{(WIDTH-1){1'b0}}, carry_in})
        else $error("R7 carry-in not treated as bit-0 generate");
    end
  end
endmodule

// File: tb/test_bk_adder.sv
module test_bk_adder;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic [W-1:0] a, b, s;
  logic         ci, co;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bk_adder #(.WIDTH(W)) i_bk_adder (
    .a_i(a), .b_i(b), .carry_in(ci), .sum_o(s), .carry_out(co)
  );

  // {a, b, cin, expected sum, expected cout}
  localparam logic [25:0] VEC [12] = '{
    {8'h00, 8'h00, 1'b0, 8'h00, 1'b0},
    {8'h00, 8'h00, 1'b1, 8'h01, 1'b0},
    {8'hFF, 8'h01, 1'b0, 8'h00, 1'b1},
    {8'hFF, 8'h00, 1'b1, 8'h00, 1'b1},
    {8'h55, 8'hAA, 1'b0, 8'hFF, 1'b0},
    {8'h55, 8'hAA, 1'b1, 8'h00, 1'b1},
    {8'h0F, 8'hF0, 1'b1, 8'h00, 1'b1},
    {8'h80, 8'h80, 1'b0, 8'h00, 1'b1},
    {8'h7F, 8'h01, 1'b0, 8'h80, 1'b0},
    {8'h3C, 8'h5A, 1'b1, 8'h97, 1'b0},
    {8'hFF, 8'hFF, 1'b1, 8'hFF, 1'b1},
    {8'h12, 8'h34, 1'b0, 8'h46, 1'b0}
  };

  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
    @(negedge clk);
    a = av; b = bv; ci = cv;
    #5;
  endtask

  task automatic chk(input string req, input logic [W-1:0] se, input logic ce);
    total++;
    if (s !== se || co !== ce) begin
      bad++;
      $display("FAIL %s: a=%h b=%h cin=%b got sum=%h cout=%b exp sum=%h cout=%b",
               req, a, b, ci, s, co, se, ce);
    end
  endtask

  initial begin
    a = '0; b = '0; ci = 1'b0;
    // Idle state: zero inputs give zero outputs (R1).
    apply('0, '0, 1'b0);
    chk("R1 idle", 8'h00, 1'b0);

    // Vector table (R1, R2, R3, R4, R7 patterns).
    for (int k = 0; k < 12; k++) begin
      apply(VEC[k][25:18], VEC[k][17:10], VEC[k][9]);
      chk("R1/R2 table", VEC[k][8:1], VEC[k][0]);
    end

    // R3: all-propagate patterns with both carry-in values.
    for (int k = 0; k < 4; k++) begin
      logic [W-1:0] pat;
      pat = (k == 0) ? 8'h00 : (k == 1) ? 8'hC3 : (k == 2) ? 8'h96 : 8'hFF;
      apply(pat, ~pat, 1'b0); chk("R3 propagate cin=0", 8'hFF, 1'b0);
      apply(pat, ~pat, 1'b1); chk("R3 propagate cin=1", 8'h00, 1'b1);
    end

    // R4: all ones plus one, either operand side.
    apply(8'h01, 8'hFF, 1'b0); chk("R4 one plus ones", 8'h00, 1'b1);
    apply(8'h00, 8'hFF, 1'b1); chk("R4 ones plus cin", 8'h00, 1'b1);

    // R7: carry-in alone.
    apply(8'h00, 8'h00, 1'b1); chk("R7 cin only", 8'h01, 1'b0);

    // R8: same inputs after different histories give the same result.
    apply(8'hFF, 8'hFF, 1'b1);
    apply(8'h3C, 8'h5A, 1'b1); chk("R8 history A", 8'h97, 1'b0);
    apply(8'h00, 8'h00, 1'b0);
    apply(8'h3C, 8'h5A, 1'b1); chk("R8 history B", 8'h97, 1'b0);

    // Exhaustive sweep; the tree assertions (R5, R6) run on every vector.
    for (int c = 0; c < 2; c++) begin
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          logic [W:0] e;
          e = 9'(x) + 9'(y) + 9'(c);
          apply(W'(x), W'(y), c[0]);
          chk("R1/R2/R5/R6 sweep", e[W-1:0], e[W]);
        end
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(190000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: R8 run did not complete, got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule